// File: doc/BRIEF.md
# Fixed Off-Time PWM Chopper

This block is the digital timing control for one H-bridge current regulator that chops at a fixed off time. It switches a diagonal source/sink transistor pair on so that winding current rises. It watches a current-trip comparator, which is first brought into the clock domain by a synchronizer. Once that comparator trips, the block holds the source off for a programmed number of cycles. During that interval the sink follows the selected decay style: slow decay keeps it on, fast decay keeps it off, and mixed decay keeps it off for a fast portion and then turns it on.

After each switch-on, the comparator is blanked for a programmed number of cycles, so switching transients cannot end the on phase early. Every handover between drive patterns passes through a cycle in which both gates are off, which prevents crossover conduction. When the enable input is dropped, both gates turn off in the same cycle. When it returns, a fresh on phase starts with blanking.

Top module: `pwm_chopper`

## Requirements
- R1: While `rst_n` is low, both `src_on` and `snk_on` are 0. With `en` high, the first clock edge after reset release starts an on phase.
- R2: During an on phase, `src_on` and `snk_on` are both 1.
- R3: In an on phase, a trip is ignored for the first `blank_cycles` cycles. With the synchronized trip held high, the on phase lasts exactly `blank_cycles`+1 cycles.
- R4: `trip_in` passes through a two-flop synchronizer. A trip applied before edge n, with blanking over, ends the on phase at edge n+2.
- R5: Slow decay (`decay_sel`=2'b00): in each off cycle after the first, `src_on`=0 and `snk_on`=1.
- R6: Fast decay (`decay_sel`=2'b01): both gates stay 0 for the whole off time.
- R7: Mixed decay (`decay_sel`=2'b10 or 2'b11): off cycle k (counted from 0) has `snk_on`=1 only when k≥1 and k≥F, where F is `fast_cycles` clamped to the off length. `src_on` is 0 throughout.
- R8: The off time lasts `off_cycles` cycles, or 1 cycle when `off_cycles` is 0, whatever the trip input does during it.
- R9: The first off cycle, and one cycle between the end of the off time and the next on phase, have both gates 0.
- R10: `en` low forces both outputs to 0 in the same cycle and returns the block to idle. Raising `en` again starts an on phase at the next edge, with blanking.
- R11: The decay mode, off length and fast portion are captured when the trip is taken. Changes to them during an off time take effect only from the next trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Active-high enable; low forces both gates off |
| trip_in | input | 1 | Asynchronous current-trip comparator output |
| decay_sel | input | 2 | 00 slow, 01 fast, 1x mixed decay |
| off_cycles | input | CW | Off-time length in cycles (0 treated as 1) |
| blank_cycles | input | CW | Blanking length after switch-on, in cycles |
| fast_cycles | input | CW | Fast-decay portion of mixed decay, in cycles |
| src_on | output | 1 | Source gate enable |
| snk_on | output | 1 | Sink gate enable |

## Verification
A trip can arrive in the same cycle that the blanking window closes, and the enable can fall in the same cycle that a trip is taken or an off time ends. The first collision is provoked by holding the trip high across switch-on with small blank counts; both are also reached by random trips mixed with rare enable drops. A bench-side cycle model judges each collision: the on phase must end exactly at the first unblanked cycle, and a falling enable must take priority over any phase advance, leaving both gates off.

// File: rtl/pwm_chop_pkg.sv
package pwm_chop_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2,
    PH_DEAD = 2'd3
  } phase_t;

  localparam logic [1:0] DK_SLOW = 2'b00;
  localparam logic [1:0] DK_FAST = 2'b01;
endpackage

// File: rtl/pwm_trip_sync.sv
module pwm_trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pwm_decay_shaper.sv
module pwm_decay_shaper #(
  parameter int CW = 8
) (
  input  logic [1:0]    mode,
  input  logic [CW-1:0] off_idx,
  input  logic [CW-1:0] fast_len,
  output logic          sink_keep
);
  import pwm_chop_pkg::*;

  logic first_cycle;
  assign first_cycle = (off_idx == '0);

  always_comb begin
    if (first_cycle)             sink_keep = 1'b0;
    else if (mode == DK_SLOW)    sink_keep = 1'b1;
    else if (mode == DK_FAST)    sink_keep = 1'b0;
    else                         sink_keep = (off_idx >= fast_len);
  end
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper #(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          trip_in,
  input  logic [1:0]    decay_sel,
  input  logic [CW-1:0] off_cycles,
  input  logic [CW-1:0] blank_cycles,
  input  logic [CW-1:0] fast_cycles,
  output logic          src_on,
  output logic          snk_on
);
  import pwm_chop_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  function automatic logic [CW-1:0] off_len(input logic [CW-1:0] o);
    return (o == '0) ? ONE : o;
  endfunction

  function automatic logic [CW-1:0] fast_len(input logic [CW-1:0] f,
                                             input logic [CW-1:0] o);
    logic [CW-1:0] oe;
    oe = off_len(o);
    return (f > oe) ? oe : f;
  endfunction

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [1:0]    mode_q;
  logic [CW-1:0] off_q;
  logic [CW-1:0] fast_q;
  logic          trip_s;
  logic          blanked;
  logic          trip_take;
  logic          off_last;
  logic          off_sink;
  logic          drive_src;
  logic          drive_snk;

  pwm_trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (trip_in),
    .q_sync  (trip_s)
  );

  pwm_decay_shaper #(.CW(CW)) u_shaper (
    .mode      (mode_q),
    .off_idx   (cnt),
    .fast_len  (fast_q),
    .sink_keep (off_sink)
  );

  assign blanked   = (cnt < blank_cycles);
  assign trip_take = (ph == PH_ON) && !blanked && trip_s;
  assign off_last  = (ph == PH_OFF) && (cnt == off_q - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      mode_q <= DK_SLOW;
      off_q  <= ONE;
      fast_q <= '0;
    end else if (!en) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          ph  <= PH_ON;
          cnt <= '0;
        end
        PH_ON: begin
          if (trip_take) begin
            ph     <= PH_OFF;
            cnt    <= '0;
            mode_q <= decay_sel;
            off_q  <= off_len(off_cycles);
            fast_q <= fast_len(fast_cycles, off_cycles);
          end else if (blanked) begin
            cnt <= cnt + ONE;
          end
        end
        PH_OFF: begin
          if (off_last) begin
            ph  <= PH_DEAD;
            cnt <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: begin
          ph  <= PH_ON;
          cnt <= '0;
        end
      endcase
    end
  end

  assign drive_src = (ph == PH_ON);
  assign drive_snk = (ph == PH_ON) || ((ph == PH_OFF) && off_sink);
  assign src_on    = en && drive_src;
  assign snk_on    = en && drive_snk;

  // R9: the source never turns on while the sink was on in the prior cycle
  p_dead_before_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_on && !$past(src_on)) |-> !$past(snk_on));

  // R9: the cycle right after a trip has both gates off
  p_first_off_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && trip_take) |=> (!snk_on && !src_on));

  // R9: the dead cycle hands over only to an on phase or to idle
  p_dead_leads_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DEAD) |=> (ph == PH_ON || ph == PH_IDLE));

  // R3: a blanked on phase cannot be left except through a disable
  p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_ON && blanked && en) |=> (ph == PH_ON || ph == PH_IDLE));

  // R8: the off time is not cut short
  p_off_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_OFF && en && !off_last) |=> (ph == PH_OFF || ph == PH_IDLE));

  // R5: the source is off throughout the off time
  p_off_src_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_OFF) |-> !src_on);

  // R6: fast decay keeps the sink off for the whole off time
  p_fast_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_OFF && mode_q == DK_FAST) |-> !snk_on);

  // R10: a low enable returns the block to idle
  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ph == PH_IDLE));
endmodule

// File: tb/pwm_chopper_tb.sv
module pwm_chopper_tb;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          trip_in;
  logic [1:0]    decay_sel;
  logic [CW-1:0] off_cycles;
  logic [CW-1:0] blank_cycles;
  logic [CW-1:0] fast_cycles;
  logic          src_on;
  logic          snk_on;

  int  n_vec  = 0;
  int  n_bad  = 0;
  bit  done   = 0;

  // bench cycle model
  int m_ph;      // 0 idle, 1 on, 2 off, 3 dead
  int m_cnt;
  int m_mode;
  int m_off;
  int m_fast;
  int d1, d2;

  always #10 clk = ~clk;

  pwm_chopper #(.CW(CW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .trip_in      (trip_in),
    .decay_sel    (decay_sel),
    .off_cycles   (off_cycles),
    .blank_cycles (blank_cycles),
    .fast_cycles  (fast_cycles),
    .src_on       (src_on),
    .snk_on       (snk_on)
  );

  function automatic int ref_off(int o);
    if (o < 1) return 1;
    return o;
  endfunction

  function automatic int ref_fast(int f, int o);
    int lim;
    lim = ref_off(o);
    if (f < lim) return f;
    return lim;
  endfunction

  function automatic bit ref_sink_in_off(int mode, int k, int flen);
    if (k == 0) return 0;
    case (mode)
      0:       return 1;
      1:       return 0;
      default: return (k >= flen);
    endcase
  endfunction

  function automatic string phase_tag();
    if (!rst_n)     return "R1";
    if (!en)        return "R10";
    if (m_ph == 1)  return "R2";
    if (m_ph == 3)  return "R9";
    if (m_ph == 2) begin
      if (m_cnt == 0)  return "R9";
      if (m_mode == 0) return "R5";
      if (m_mode == 1) return "R6";
      return "R7";
    end
    return "R10";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int sampled;
    sampled = d2;
    d2 = d1;
    d1 = int'(trip_in);
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_mode = 0; m_off = 1; m_fast = 0; d1 = 0; d2 = 0;
    end else if (!en) begin
      m_ph = 0; m_cnt = 0;
    end else begin
      case (m_ph)
        0: begin m_ph = 1; m_cnt = 0; end
        1: begin
          if (m_cnt >= int'(blank_cycles) && sampled == 1) begin
            m_ph   = 2;
            m_cnt  = 0;
            m_mode = (decay_sel[1]) ? 2 : int'(decay_sel);
            m_off  = ref_off(int'(off_cycles));
            m_fast = ref_fast(int'(fast_cycles), int'(off_cycles));
          end else if (m_cnt < int'(blank_cycles)) begin
            m_cnt++;
          end
        end
        2: begin
          if (m_cnt + 1 >= m_off) begin m_ph = 3; m_cnt = 0; end
          else m_cnt++;
        end
        default: begin m_ph = 1; m_cnt = 0; end
      endcase
    end
  endtask

  task automatic model_compare();
    bit es, ek;
    es = rst_n && en && (m_ph == 1);
    ek = rst_n && en && ((m_ph == 1) ||
                        (m_ph == 2 && ref_sink_in_off(m_mode, m_cnt, m_fast)));
    check(src_on === es, {phase_tag(), " src_on"}, int'(src_on), int'(es));
    check(snk_on === ek, {phase_tag(), " snk_on"}, int'(snk_on), int'(ek));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    model_compare();
  endtask

  task automatic setup(input logic [1:0] m, input int o, input int b, input int f);
    decay_sel    = m;
    off_cycles   = CW'(o);
    blank_cycles = CW'(b);
    fast_cycles  = CW'(f);
  endtask

  // wait until the source has just switched on, at a sampling point
  task automatic wait_src_rise();
    bit prev;
    prev = src_on;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (src_on && !prev) return;
      prev = src_on;
    end
    check(1'b0, "R2 no switch-on seen", 0, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int run;
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; en = 1'b1; trip_in = 1'b1;
    setup(2'b00, 5, 3, 2);
    m_ph = 0; m_cnt = 0; m_mode = 0; m_off = 1; m_fast = 0; d1 = 0; d2 = 0;

    // R1: reset holds both gates off even with enable and trip high
    repeat (3) begin
      tick();
      check(!src_on && !snk_on, "R1 reset gates", int'({src_on, snk_on}), 0);
    end
    rst_n = 1'b1;
    tick();
    check(src_on && snk_on, "R1 on phase after reset", int'({src_on, snk_on}), 3);

    // R3: trip held high, on phase length equals blank+1
    setup(2'b00, 4, 5, 0);
    wait_src_rise();
    run = 1;
    while (src_on && run < 100) begin tick(); if (src_on) run++; end
    check(run == 6, "R3 on length blank=5", run, 6);

    setup(2'b01, 3, 0, 0);
    wait_src_rise();
    run = 1;
    while (src_on && run < 100) begin tick(); if (src_on) run++; end
    check(run == 1, "R3 on length blank=0", run, 1);

    // R4: trip raised with blanking over, on phase ends two edges later
    trip_in = 1'b0;
    setup(2'b00, 2, 0, 0);
    repeat (12) tick();
    check(src_on == 1'b1, "R4 on while no trip", int'(src_on), 1);
    trip_in = 1'b1;
    tick();
    check(src_on == 1'b1, "R4 edge 1 still on", int'(src_on), 1);
    tick();
    check(src_on == 1'b1, "R4 edge 2 still on", int'(src_on), 1);
    tick();
    check(src_on == 1'b0 && snk_on == 1'b0, "R4 edge 3 off", int'({src_on, snk_on}), 0);

    // R5 R6 R7 R8 R9: each decay style and off length, trip held high
    trip_in = 1'b1;
    setup(2'b00, 6, 2, 0);   repeat (40) tick();
    setup(2'b01, 5, 1, 0);   repeat (40) tick();
    setup(2'b10, 7, 2, 3);   repeat (40) tick();
    setup(2'b11, 4, 1, 9);   repeat (40) tick();   // R7 clamp of fast portion
    setup(2'b00, 0, 0, 0);   repeat (30) tick();   // R8 zero off length

    // R8: trip toggling during the off time does not shorten it
    setup(2'b00, 8, 0, 0);
    wait_src_rise();
    while (src_on) tick();
    run = 0;
    while (!src_on && run < 100) begin trip_in = ~trip_in; tick(); run++; end
    check(run == 9, "R8 off plus dead length", run, 9);
    trip_in = 1'b1;

    // R11: settings changed inside an off time are not applied to it
    setup(2'b00, 6, 0, 0);
    wait_src_rise();
    while (src_on) tick();
    setup(2'b01, 2, 0, 0);
    tick();
    check(snk_on == 1'b1, "R11 captured slow mode", int'(snk_on), 1);
    repeat (10) tick();

    // R10: enable low gates off in the same cycle, restart with blanking
    setup(2'b00, 3, 4, 0);
    wait_src_rise();
    en = 1'b0;
    #1;
    check(!src_on && !snk_on, "R10 immediate gate off", int'({src_on, snk_on}), 0);
    repeat (3) tick();
    en = 1'b1;
    tick();
    check(src_on && snk_on, "R10 restart on phase", int'({src_on, snk_on}), 3);
    repeat (20) tick();

    // random traffic against the bench model
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 60) == 0)
        setup(2'($urandom % 4), int'($urandom % 13), int'($urandom % 7),
              int'($urandom % 15));
      if (($urandom % 3) == 0) trip_in = 1'($urandom % 2);
      if (!en) en = (($urandom % 4) == 0);
      else     en = (($urandom % 150) != 0);
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule